// File: doc/BRIEF.md
# Transmit Packet Queue with Completion Tracking

This block keeps the packet numbers that drive frame transmission. Software writes a packet number into the block and issues an enqueue command; the number joins an in-order transmit queue. While transmission is enabled and a number is waiting, the block raises a request to the MAC and presents the number at the head of the queue. When the MAC reports that a frame has finished and that it can take the next one, the head leaves the transmit queue.

A retired number has one of two destinations. In auto-free mode, after a successful send, the number goes out on a one-cycle release port to the memory manager and is never stored. In every other case it moves into a completion queue. It stays there until software acknowledges it. Software sees the head of the completion queue, a transmit-interrupt bit that is set while that queue holds entries, and a transmit-empty bit for the transmit queue. Frame data never passes through the block.

Top module: `pktq_tx_track`

## Requirements
- R1: After a synchronous reset both queues are empty. `stat_tx_empty` is 1, and `stat_tx_int`, `stat_enq_err`, `rel_valid` and `mac_req` are 0.
- R2: A pulse on `cpu_enq` stores `cpu_pnum` in the transmit queue. `mac_pnum` always shows the oldest stored number, and numbers leave in the order they were stored.
- R3: `mac_req` is 1 exactly when `cfg_tx_en` is 1, the transmit queue is not empty and the completion queue has room.
- R4: A `mac_done` pulse retires the transmit queue head. When the retired number is not freed, it is appended to the completion queue and is visible one cycle later.
- R5: When `mac_done` comes with `mac_ok`=1 and `cfg_auto_rel`=1, `rel_valid` is 1 for the following cycle and `rel_pnum` carries the retired number. That number is not stored in the completion queue.
- R6: When `mac_done` comes with `mac_ok`=0, the number goes to the completion queue and no release is made, even with `cfg_auto_rel`=1.
- R7: `stat_tx_int` is 1 while the completion queue holds entries, and `stat_done_head` shows its oldest entry. A `cpu_tx_ack` pulse removes that entry.
- R8: `mac_done` is ignored while the transmit queue is empty or the completion queue is full, independent of `cfg_tx_en`. `cpu_tx_ack` on an empty completion queue is ignored.
- R9: `cpu_enq` into a full transmit queue (8 entries) is dropped, and `stat_enq_err` is set. The flag stays set until reset.
- R10: `stat_tx_empty` is 1 exactly when the transmit queue holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_pnum | input | 6 | Packet number register value |
| cpu_enq | input | 1 | Enqueue command pulse |
| cpu_tx_ack | input | 1 | Transmit-interrupt acknowledge; removes the completion head |
| cfg_tx_en | input | 1 | Transmission enable |
| cfg_auto_rel | input | 1 | Free memory automatically after a successful send |
| stat_tx_empty | output | 1 | Transmit queue empty |
| stat_tx_int | output | 1 | Completion queue not empty |
| stat_done_head | output | 6 | Oldest completion queue entry |
| stat_enq_err | output | 1 | Sticky flag: enqueue into a full queue |
| mac_req | output | 1 | Frame waiting and allowed to start |
| mac_pnum | output | 6 | Packet number of the frame to send |
| mac_done | input | 1 | Frame finished and MAC ready for the next one |
| mac_ok | input | 1 | Finished frame was sent successfully |
| rel_valid | output | 1 | Release command to the memory manager |
| rel_pnum | output | 6 | Packet number to release |

## Verification
Every stored result has a latency of one clock. An enqueue, a retirement or an acknowledge applied at one rising edge shows on the status, head and release outputs after that edge. `mac_req` is the only output that follows `cfg_tx_en` within the same cycle. The bench drives each stimulus on a falling edge and holds it through the next rising edge. It samples on the falling edge that follows, so registered results are settled and the combinational request still sees the stimulus that was applied. Head values and release numbers are compared only when their matching valid or not-empty bit is expected.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
    localparam int PNUM_W  = 6;
    localparam int Q_DEPTH = 8;

    typedef logic [PNUM_W-1:0] pnum_t;

    // Where a retired packet number goes
    typedef enum logic [1:0] {
        DISP_NONE  = 2'd0,
        DISP_STORE = 2'd1,
        DISP_FREE  = 2'd2
    } disp_e;

    typedef struct packed {
        logic  valid;
        pnum_t pnum;
    } rel_t;

    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/pktq_fifo.sv
module pktq_fifo
    import pktq_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  pnum_t wdata,
    input  logic  pop,
    output pnum_t rdata,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pnum_t          mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
            end
            if (do_pop)
                rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pktq_ctrl.sv
module pktq_ctrl
    import pktq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_tx_en,
    input  logic  cfg_auto_rel,
    input  logic  tx_empty,
    input  logic  done_full,
    input  pnum_t tx_head,
    input  logic  mac_done,
    input  logic  mac_ok,
    output logic  mac_req,
    output logic  tx_pop,
    output logic  done_push,
    output rel_t  rel
);
    disp_e disp;
    logic  can_retire;
    rel_t  rel_q;

    always_comb begin
        can_retire = mac_done && !tx_empty && !done_full;
        if (!can_retire)
            disp = DISP_NONE;
        else if (cfg_auto_rel && mac_ok)
            disp = DISP_FREE;
        else
            disp = DISP_STORE;
        tx_pop    = (disp != DISP_NONE);
        done_push = (disp == DISP_STORE);
        mac_req   = cfg_tx_en && !tx_empty && !done_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_q <= '0;
        end else begin
            rel_q.valid <= (disp == DISP_FREE);
            rel_q.pnum  <= tx_head;
        end
    end

    assign rel = rel_q;
endmodule

// File: rtl/pktq_tx_track.sv
module pktq_tx_track
    import pktq_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PNUM_W-1:0] cpu_pnum,
    input  logic              cpu_enq,
    input  logic              cpu_tx_ack,
    input  logic              cfg_tx_en,
    input  logic              cfg_auto_rel,
    output logic              stat_tx_empty,
    output logic              stat_tx_int,
    output logic [PNUM_W-1:0] stat_done_head,
    output logic              stat_enq_err,
    output logic              mac_req,
    output logic [PNUM_W-1:0] mac_pnum,
    input  logic              mac_done,
    input  logic              mac_ok,
    output logic              rel_valid,
    output logic [PNUM_W-1:0] rel_pnum
);
    pnum_t tx_head, done_head;
    logic  tx_empty, tx_full, done_empty, done_full;
    logic  tx_pop, done_push;
    logic  err_q;
    rel_t  rel;

    pktq_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (cpu_enq),
        .wdata (cpu_pnum),
        .pop   (tx_pop),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    pktq_fifo #(.DEPTH(DEPTH)) u_doneq (
        .clk   (clk),
        .rst   (rst),
        .push  (done_push),
        .wdata (tx_head),
        .pop   (cpu_tx_ack),
        .rdata (done_head),
        .empty (done_empty),
        .full  (done_full)
    );

    pktq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_tx_en    (cfg_tx_en),
        .cfg_auto_rel (cfg_auto_rel),
        .tx_empty     (tx_empty),
        .done_full    (done_full),
        .tx_head      (tx_head),
        .mac_done     (mac_done),
        .mac_ok       (mac_ok),
        .mac_req      (mac_req),
        .tx_pop       (tx_pop),
        .done_push    (done_push),
        .rel          (rel)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (cpu_enq && tx_full)
            err_q <= 1'b1;
    end

    assign stat_tx_empty  = tx_empty;
    assign stat_tx_int    = !done_empty;
    assign stat_done_head = done_head;
    assign stat_enq_err   = err_q;
    assign mac_pnum       = tx_head;
    assign rel_valid      = rel.valid;
    assign rel_pnum       = rel.pnum;
endmodule

// File: rtl/pktq_tx_track_chk.sv
module pktq_tx_track_chk (
    input logic clk,
    input logic rst,
    input logic cpu_enq,
    input logic cfg_tx_en,
    input logic cfg_auto_rel,
    input logic stat_tx_empty,
    input logic stat_tx_int,
    input logic stat_enq_err,
    input logic mac_req,
    input logic mac_done,
    input logic mac_ok,
    input logic rel_valid
);
    assert_req_gate_R3: assert property (@(posedge clk) disable iff (rst)
        mac_req |-> (cfg_tx_en && !stat_tx_empty));

    assert_fill_from_enq_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_tx_empty) |-> $past(cpu_enq));

    assert_int_from_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_tx_int) |-> $past(mac_done));

    assert_rel_cause_R5: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> $past(mac_done && mac_ok && cfg_auto_rel));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        stat_enq_err |=> stat_enq_err);
endmodule

bind pktq_tx_track pktq_tx_track_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_enq       (cpu_enq),
    .cfg_tx_en     (cfg_tx_en),
    .cfg_auto_rel  (cfg_auto_rel),
    .stat_tx_empty (stat_tx_empty),
    .stat_tx_int   (stat_tx_int),
    .stat_enq_err  (stat_enq_err),
    .mac_req       (mac_req),
    .mac_done      (mac_done),
    .mac_ok        (mac_ok),
    .rel_valid     (rel_valid)
);

// File: tb/pktq_tx_track_bench.sv
`timescale 1ns/1ps
module pktq_tx_track_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cpu_pnum = '0;
    logic       cpu_enq = 1'b0, cpu_tx_ack = 1'b0;
    logic       cfg_tx_en = 1'b0, cfg_auto_rel = 1'b0;
    logic       mac_done = 1'b0, mac_ok = 1'b0;
    logic       stat_tx_empty, stat_tx_int, stat_enq_err, mac_req, rel_valid;
    logic [5:0] stat_done_head, mac_pnum, rel_pnum;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pktq_tx_track u_pktq_tx_track (
        .clk(clk), .rst(rst), .cpu_pnum(cpu_pnum), .cpu_enq(cpu_enq),
        .cpu_tx_ack(cpu_tx_ack), .cfg_tx_en(cfg_tx_en), .cfg_auto_rel(cfg_auto_rel),
        .stat_tx_empty(stat_tx_empty), .stat_tx_int(stat_tx_int),
        .stat_done_head(stat_done_head), .stat_enq_err(stat_enq_err),
        .mac_req(mac_req), .mac_pnum(mac_pnum), .mac_done(mac_done),
        .mac_ok(mac_ok), .rel_valid(rel_valid), .rel_pnum(rel_pnum)
    );

    typedef struct packed {
        logic       en, au, enq;
        logic [5:0] pn;
        logic       dn, ok, ack;
        logic       x_txe, x_int;
        logic [5:0] x_head;
        logic       x_req;
        logic [5:0] x_mpn;
        logic       x_rel;
        logic [5:0] x_rpn;
    } vec_t;

    // en au enq pn dn ok ack | txe int head req mpn rel rpn
    localparam vec_t VEC [13] = '{
        '{1'b1,1'b0,1'b1,6'd5, 1'b0,1'b0,1'b0, 1'b0,1'b0,6'd0, 1'b1,6'd5, 1'b0,6'd0},
        '{1'b1,1'b0,1'b1,6'd9, 1'b0,1'b0,1'b0, 1'b0,1'b0,6'd0, 1'b1,6'd5, 1'b0,6'd0},
        '{1'b1,1'b0,1'b1,6'd12,1'b0,1'b0,1'b0, 1'b0,1'b0,6'd0, 1'b1,6'd5, 1'b0,6'd0},
        '{1'b1,1'b0,1'b0,6'd0, 1'b1,1'b1,1'b0, 1'b0,1'b1,6'd5, 1'b1,6'd9, 1'b0,6'd0},
        '{1'b1,1'b1,1'b0,6'd0, 1'b1,1'b0,1'b0, 1'b0,1'b1,6'd5, 1'b1,6'd12,1'b0,6'd0},
        '{1'b1,1'b1,1'b0,6'd0, 1'b1,1'b1,1'b0, 1'b1,1'b1,6'd5, 1'b0,6'd0, 1'b1,6'd12},
        '{1'b1,1'b1,1'b0,6'd0, 1'b0,1'b0,1'b1, 1'b1,1'b1,6'd9, 1'b0,6'd0, 1'b0,6'd0},
        '{1'b1,1'b1,1'b0,6'd0, 1'b0,1'b0,1'b1, 1'b1,1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0},
        '{1'b1,1'b1,1'b0,6'd0, 1'b0,1'b0,1'b1, 1'b1,1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0},
        '{1'b1,1'b1,1'b0,6'd0, 1'b1,1'b1,1'b0, 1'b1,1'b0,6'd0, 1'b0,6'd0, 1'b0,6'd0},
        '{1'b0,1'b1,1'b1,6'd33,1'b0,1'b0,1'b0, 1'b0,1'b0,6'd0, 1'b0,6'd33,1'b0,6'd0},
        '{1'b0,1'b0,1'b1,6'd40,1'b1,1'b1,1'b0, 1'b0,1'b1,6'd33,1'b0,6'd40,1'b0,6'd0},
        '{1'b1,1'b1,1'b0,6'd0, 1'b1,1'b1,1'b1, 1'b1,1'b0,6'd0, 1'b0,6'd0, 1'b1,6'd40}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive after a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(input logic en, input logic au, input logic enq, input logic [5:0] pn,
                        input logic dn, input logic ok, input logic ack);
        cfg_tx_en = en; cfg_auto_rel = au; cpu_enq = enq; cpu_pnum = pn;
        mac_done = dn; mac_ok = ok; cpu_tx_ack = ack;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_reset_state();
        chk("R1 tx_empty", int'(stat_tx_empty), 1);
        chk("R1 tx_int", int'(stat_tx_int), 0);
        chk("R1 enq_err", int'(stat_enq_err), 0);
        chk("R1 rel_valid", int'(rel_valid), 0);
        chk("R1 mac_req", int'(mac_req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cfg_tx_en = 1'b1;
        rst = 1'b0;
        step(1, 0, 0, 0, 0, 0, 0);
        chk_reset_state();

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 13; i++) begin
            step(VEC[i].en, VEC[i].au, VEC[i].enq, VEC[i].pn, VEC[i].dn, VEC[i].ok, VEC[i].ack);
            chk("R10 tx_empty", int'(stat_tx_empty), int'(VEC[i].x_txe));
            chk("R7 tx_int", int'(stat_tx_int), int'(VEC[i].x_int));
            chk("R3 mac_req", int'(mac_req), int'(VEC[i].x_req));
            chk("R5 rel_valid", int'(rel_valid), int'(VEC[i].x_rel));
            if (VEC[i].x_int) chk("R7 done_head", int'(stat_done_head), int'(VEC[i].x_head));
            if (!VEC[i].x_txe) chk("R2 mac_pnum", int'(mac_pnum), int'(VEC[i].x_mpn));
            if (VEC[i].x_rel) chk("R5 rel_pnum", int'(rel_pnum), int'(VEC[i].x_rpn));
        end

        // R9: overflow of the transmit queue
        for (int k = 0; k < 8; k++) step(0, 1, 1, 6'(k + 1), 0, 0, 0);
        chk("R9 no error while filling", int'(stat_enq_err), 0);
        step(0, 1, 1, 6'd63, 0, 0, 0);
        chk("R9 enq_err set", int'(stat_enq_err), 1);
        chk("R10 not empty when full", int'(stat_tx_empty), 0);
        for (int k = 0; k < 8; k++) begin
            step(0, 1, 0, 0, 1, 1, 0);
            chk("R5 drain release", int'(rel_valid), 1);
            chk("R2 drain order", int'(rel_pnum), k + 1);
        end
        chk("R9 dropped entry absent", int'(stat_tx_empty), 1);
        step(0, 1, 0, 0, 1, 1, 0);
        chk("R8 done on empty queue", int'(rel_valid), 0);
        chk("R9 flag sticky", int'(stat_enq_err), 1);

        // R6: failed send under auto-free
        step(0, 1, 1, 6'd7, 0, 0, 0);
        step(0, 1, 0, 0, 1, 0, 0);
        chk("R6 no release on failure", int'(rel_valid), 0);
        chk("R6 stored on failure", int'(stat_tx_int), 1);
        chk("R6 stored number", int'(stat_done_head), 7);
        step(0, 1, 0, 0, 0, 0, 1);
        chk("R7 ack empties", int'(stat_tx_int), 0);

        // R3 R4 R8: full completion queue blocks retirement
        for (int k = 0; k < 8; k++) step(0, 0, 1, 6'(k + 10), 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 0);
        chk("R4 head after first retire", int'(stat_done_head), 10);
        for (int k = 1; k < 8; k++) step(0, 0, 0, 0, 1, 1, 0);
        chk("R4 all retired", int'(stat_tx_empty), 1);
        step(0, 0, 1, 6'd20, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R3 req low when completion full", int'(mac_req), 0);
        step(1, 0, 0, 0, 1, 1, 0);
        chk("R8 done ignored when full", int'(stat_tx_empty), 0);
        chk("R8 head kept", int'(mac_pnum), 20);
        chk("R8 completion head kept", int'(stat_done_head), 10);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R3 req after room", int'(mac_req), 1);
        chk("R7 ack advances head", int'(stat_done_head), 11);

        // R1: reset in mid-run
        rst = 1'b1;
        step(1, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        chk_reset_state();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule